// File: doc/BRIEF.md
# Vector Compare-Immediate Sequencer with Fail-First Truncation

This block steps a signed compare-with-immediate across a run of integer register elements, one element per clock. For every element it reads one integer register through a read port, compares it against a sign-extended immediate, and writes a 4-bit condition field into a small condition register file. The source index and the destination index each either advance with the element number or stay pinned to their base. Which one applies is set per operand by a vector/scalar flag. Scalar-to-vector, vector-to-scalar and vector-to-vector forms therefore share one datapath.

When fail-first is enabled, a selectable test is applied to each element's condition field. The first element that fails the test ends the loop and rewrites the vector length. In inclusive mode the failing element is kept: its condition write commits and the new length is the index plus one. In exclusive mode the failing element is dropped: its write is suppressed and the new length equals its index, which can be zero. A one-cycle done pulse reports the final length. When no element fails, the length is returned unchanged.

Top module: `vcmp_ffirst`

## Requirements
- R1: While and right after reset, `busy`, `done` and `cr_we` are 0.
- R2: Each condition write carries `cr_data` = {LT, GT, EQ, SO}. LT is bit 3, GT is bit 2, EQ is bit 1 and SO is bit 0. They come from a signed compare of `rf_data` against `imm` sign-extended to XLEN. SO is always 0.
- R3: For element i, `rf_addr` is `ra_base + i` (modulo the register count) when `ra_vec` is 1, and `ra_base` for every element when it is 0.
- R4: For element i, `cr_addr` is `ba_base + i` (modulo the field count) when `ba_vec` is 1, and `ba_base` for every element when it is 0.
- R5: Elements are processed one per clock, starting the cycle after `start` is taken. `done` rises the cycle after the last processed element. When no element fails, exactly `vl_in` writes occur and `vl_out` equals `vl_in`.
- R6: `test_sel` picks the tested bit: 0 = LT, 1 = GT, 2 = EQ, 3 = SO. `test_pol` = 1 fails when that bit is set, and 0 fails when it is clear. With `ffirst_en` = 0 no element ever fails.
- R7: In inclusive mode (`incl` = 1), a failing element at index i is written, the loop stops, and `vl_out` = i+1.
- R8: In exclusive mode (`incl` = 0), a failing element at index i is not written, the loop stops, and `vl_out` = i. A failure on element 0 gives 0.
- R9: `done` is high for exactly one cycle per accepted request.
- R10: A `start` pulse while `busy` is 1 is ignored and does not change the running operation.
- R11: A request with `vl_in` = 0 gives `done` on the next cycle with `vl_out` = 0 and no condition write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request pulse, taken only when idle |
| vl_in | input | VLW | Requested vector length |
| ra_base | input | RIDXW | Source integer register base index |
| ba_base | input | CIDXW | Destination condition field base index |
| ra_vec | input | 1 | Source index steps per element |
| ba_vec | input | 1 | Destination index steps per element |
| imm | input | IMMW | Signed immediate operand |
| ffirst_en | input | 1 | Enable fail-first truncation |
| test_sel | input | 2 | Condition bit tested for failure |
| test_pol | input | 1 | Fail when bit set (1) or clear (0) |
| incl | input | 1 | Inclusive (1) or exclusive (0) truncation |
| rf_addr | output | RIDXW | Integer register read address |
| rf_data | input | XLEN | Integer register read data, same cycle |
| cr_we | output | 1 | Condition field write enable |
| cr_addr | output | CIDXW | Condition field write index |
| cr_data | output | 4 | Condition field value |
| busy | output | 1 | Element loop in progress |
| done | output | 1 | One-cycle completion pulse |
| vl_out | output | VLW | Final vector length, valid with done |

## Verification
On every cycle the assertions check several properties. Written condition fields hold exactly one of LT, GT and EQ with SO clear. Writes occur only while busy. Read and write indices either hold or step by one inside a run. Done is a single-cycle pulse, and a zero-length request completes on the next cycle. The bench scenarios are the only place that shows the data-dependent parts. These are the exact element where a run stops, the inclusive and exclusive length values including truncation to zero, suppression of the failing write, index wrap-around on long runs, and that a start during a run leaves it untouched.

// File: rtl/vcmp_pkg.sv
package vcmp_pkg;

    // Tested-bit selector encoding
    typedef enum logic [1:0] {
        SEL_LT = 2'd0,
        SEL_GT = 2'd1,
        SEL_EQ = 2'd2,
        SEL_SO = 2'd3
    } tsel_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } seq_st_e;

    // Condition field, lt in bit 3 down to so in bit 0
    typedef struct packed {
        logic lt;
        logic gt;
        logic eq;
        logic so;
    } crf_t;

    localparam int CRF_W = 4;

endpackage

// File: rtl/vcmp_compare.sv
module vcmp_compare
    import vcmp_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int IMMW = 16
) (
    input  logic [XLEN-1:0] opnd,
    input  logic [IMMW-1:0] imm,
    output crf_t            res
);
    localparam int EXTW = XLEN - IMMW;

    logic signed [XLEN-1:0] a_s;
    logic signed [XLEN-1:0] b_s;

    generate
        if (EXTW > 0) begin : g_ext
            assign b_s = {{EXTW{imm[IMMW-1]}}, imm};
        end else begin : g_trunc
            assign b_s = imm[XLEN-1:0];
        end
    endgenerate

    assign a_s = opnd;

    always_comb begin
        res.lt = (a_s < b_s);
        res.gt = (a_s > b_s);
        res.eq = (a_s == b_s);
        res.so = 1'b0;
    end
endmodule

// File: rtl/vcmp_failtest.sv
module vcmp_failtest
    import vcmp_pkg::*;
(
    input  logic  en,
    input  crf_t  res,
    input  tsel_e sel,
    input  logic  pol,
    output logic  fail
);
    logic picked;

    always_comb begin
        unique case (sel)
            SEL_LT:  picked = res.lt;
            SEL_GT:  picked = res.gt;
            SEL_EQ:  picked = res.eq;
            default: picked = res.so;
        endcase
        fail = en && (picked == pol);
    end
endmodule

// File: rtl/vcmp_index.sv
module vcmp_index #(
    parameter int AW   = 5,
    parameter int OFFW = 7
) (
    input  logic [AW-1:0]   base,
    input  logic            vec,
    input  logic [OFFW-1:0] off,
    output logic [AW-1:0]   addr
);
    logic [AW-1:0] off_w;

    generate
        if (OFFW >= AW) begin : g_cut
            assign off_w = off[AW-1:0];
        end else begin : g_pad
            assign off_w = {{(AW-OFFW){1'b0}}, off};
        end
    endgenerate

    assign addr = vec ? (base + off_w) : base;
endmodule

// File: rtl/vcmp_ffirst.sv
module vcmp_ffirst
    import vcmp_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int IMMW  = 16,
    parameter int NREG  = 32,
    parameter int NCRF  = 8,
    parameter int VLMAX = 64,
    localparam int RIDXW = $clog2(NREG),
    localparam int CIDXW = $clog2(NCRF),
    localparam int VLW   = $clog2(VLMAX + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [VLW-1:0]   vl_in,
    input  logic [RIDXW-1:0] ra_base,
    input  logic [CIDXW-1:0] ba_base,
    input  logic             ra_vec,
    input  logic             ba_vec,
    input  logic [IMMW-1:0]  imm,
    input  logic             ffirst_en,
    input  logic [1:0]       test_sel,
    input  logic             test_pol,
    input  logic             incl,
    output logic [RIDXW-1:0] rf_addr,
    input  logic [XLEN-1:0]  rf_data,
    output logic             cr_we,
    output logic [CIDXW-1:0] cr_addr,
    output logic [CRF_W-1:0] cr_data,
    output logic             busy,
    output logic             done,
    output logic [VLW-1:0]   vl_out
);
    typedef struct packed {
        seq_st_e          st;
        logic [VLW-1:0]   idx;
        logic [VLW-1:0]   vl;
        logic [RIDXW-1:0] ra;
        logic [CIDXW-1:0] ba;
        logic             rav;
        logic             bav;
        logic [IMMW-1:0]  imm;
        logic             ff;
        tsel_e            sel;
        logic             pol;
        logic             incl;
        logic             done;
    } seq_t;

    localparam seq_t SEQ_RST = '{
        st:   ST_IDLE,
        idx:  '0,
        vl:   '0,
        ra:   '0,
        ba:   '0,
        rav:  1'b0,
        bav:  1'b0,
        imm:  '0,
        ff:   1'b0,
        sel:  SEL_LT,
        pol:  1'b0,
        incl: 1'b0,
        done: 1'b0
    };

    seq_t seq_d, seq_q;

    crf_t elem_res;
    logic elem_fail;
    logic last_elem;
    logic running;

    vcmp_index #(.AW(RIDXW), .OFFW(VLW)) u_src_idx (
        .base (seq_q.ra),
        .vec  (seq_q.rav),
        .off  (seq_q.idx),
        .addr (rf_addr)
    );

    vcmp_index #(.AW(CIDXW), .OFFW(VLW)) u_dst_idx (
        .base (seq_q.ba),
        .vec  (seq_q.bav),
        .off  (seq_q.idx),
        .addr (cr_addr)
    );

    vcmp_compare #(.XLEN(XLEN), .IMMW(IMMW)) u_cmp (
        .opnd (rf_data),
        .imm  (seq_q.imm),
        .res  (elem_res)
    );

    vcmp_failtest u_test (
        .en   (seq_q.ff),
        .res  (elem_res),
        .sel  (seq_q.sel),
        .pol  (seq_q.pol),
        .fail (elem_fail)
    );

    assign running   = (seq_q.st == ST_RUN);
    assign last_elem = (seq_q.idx == seq_q.vl - VLW'(1));

    // Exclusive mode drops the failing element's write
    assign cr_we   = running && !(elem_fail && !seq_q.incl);
    assign cr_data = elem_res;
    assign busy    = running;
    assign done    = seq_q.done;
    assign vl_out  = seq_q.vl;

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        unique case (seq_q.st)
            ST_IDLE: begin
                if (start) begin
                    seq_d.idx  = '0;
                    seq_d.vl   = vl_in;
                    seq_d.ra   = ra_base;
                    seq_d.ba   = ba_base;
                    seq_d.rav  = ra_vec;
                    seq_d.bav  = ba_vec;
                    seq_d.imm  = imm;
                    seq_d.ff   = ffirst_en;
                    seq_d.sel  = tsel_e'(test_sel);
                    seq_d.pol  = test_pol;
                    seq_d.incl = incl;
                    if (vl_in == '0) begin
                        seq_d.done = 1'b1;
                    end else begin
                        seq_d.st = ST_RUN;
                    end
                end
            end
            default: begin
                if (elem_fail) begin
                    seq_d.vl   = seq_q.incl ? (seq_q.idx + VLW'(1)) : seq_q.idx;
                    seq_d.st   = ST_IDLE;
                    seq_d.done = 1'b1;
                end else if (last_elem) begin
                    seq_d.st   = ST_IDLE;
                    seq_d.done = 1'b1;
                end else begin
                    seq_d.idx  = seq_q.idx + VLW'(1);
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= SEQ_RST;
        end else begin
            seq_q <= seq_d;
        end
    end
endmodule

// File: rtl/vcmp_ffirst_chk.sv
module vcmp_ffirst_chk #(
    parameter int RIDXW = 5,
    parameter int CIDXW = 3,
    parameter int VLW   = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [VLW-1:0]   vl_in,
    input logic [RIDXW-1:0] rf_addr,
    input logic             cr_we,
    input logic [CIDXW-1:0] cr_addr,
    input logic [3:0]       cr_data,
    input logic             busy,
    input logic             done,
    input logic [VLW-1:0]   vl_out
);
    assert_so_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cr_we |-> (cr_data[0] == 1'b0));

    assert_one_relation_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cr_we |-> ($countones(cr_data[3:1]) == 1));

    assert_src_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |->
            (rf_addr == $past(rf_addr) || rf_addr == RIDXW'($past(rf_addr) + 1'b1)));

    assert_dst_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |->
            (cr_addr == $past(cr_addr) || cr_addr == CIDXW'($past(cr_addr) + 1'b1)));

    assert_write_in_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cr_we |-> busy);

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> !done);

    assert_busy_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> (busy || done));

    assert_zero_len_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && vl_in == '0) |=> (done && vl_out == '0 && !cr_we));
endmodule

bind vcmp_ffirst vcmp_ffirst_chk #(
    .RIDXW (RIDXW),
    .CIDXW (CIDXW),
    .VLW   (VLW)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .vl_in   (vl_in),
    .rf_addr (rf_addr),
    .cr_we   (cr_we),
    .cr_addr (cr_addr),
    .cr_data (cr_data),
    .busy    (busy),
    .done    (done),
    .vl_out  (vl_out)
);

// File: tb/sim_vcmp_ffirst.sv
module sim_vcmp_ffirst;
    localparam int CLK_PER = 10;
    localparam int XLEN  = 32;
    localparam int IMMW  = 16;
    localparam int NREG  = 32;
    localparam int NCRF  = 8;
    localparam int VLMAX = 64;
    localparam int RIDXW = $clog2(NREG);
    localparam int CIDXW = $clog2(NCRF);
    localparam int VLW   = $clog2(VLMAX + 1);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [VLW-1:0]   vl_in = '0;
    logic [RIDXW-1:0] ra_base = '0;
    logic [CIDXW-1:0] ba_base = '0;
    logic             ra_vec = 1'b0;
    logic             ba_vec = 1'b0;
    logic [IMMW-1:0]  imm = '0;
    logic             ffirst_en = 1'b0;
    logic [1:0]       test_sel = 2'd0;
    logic             test_pol = 1'b0;
    logic             incl = 1'b0;
    logic [RIDXW-1:0] rf_addr;
    logic [XLEN-1:0]  rf_data;
    logic             cr_we;
    logic [CIDXW-1:0] cr_addr;
    logic [3:0]       cr_data;
    logic             busy;
    logic             done;
    logic [VLW-1:0]   vl_out;

    logic [XLEN-1:0] rf [NREG];

    int n_chk = 0;
    int n_bad = 0;
    string cur_req = "R1";
    logic prev_done = 1'b0;

    logic [CIDXW+3:0] exp_wr [$];
    logic [VLW-1:0]   exp_vl [$];

    always #(CLK_PER/2) clk = ~clk;

    assign rf_data = rf[rf_addr];

    vcmp_ffirst #(
        .XLEN(XLEN), .IMMW(IMMW), .NREG(NREG), .NCRF(NCRF), .VLMAX(VLMAX)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .vl_in(vl_in),
        .ra_base(ra_base), .ba_base(ba_base), .ra_vec(ra_vec), .ba_vec(ba_vec),
        .imm(imm), .ffirst_en(ffirst_en), .test_sel(test_sel), .test_pol(test_pol),
        .incl(incl), .rf_addr(rf_addr), .rf_data(rf_data), .cr_we(cr_we),
        .cr_addr(cr_addr), .cr_data(cr_data), .busy(busy), .done(done),
        .vl_out(vl_out)
    );

    task automatic check(input string req, input logic ok, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: pops expected items as the design produces them
    always @(negedge clk) begin
        if (rst_n) begin
            if (cr_we) begin
                if (exp_wr.size() == 0) begin
                    check(cur_req, 1'b0, {cr_addr, cr_data}, 0);
                end else begin
                    logic [CIDXW+3:0] e;
                    e = exp_wr.pop_front();
                    check(cur_req, {cr_addr, cr_data} == e, {cr_addr, cr_data}, e);
                end
            end
            if (done) begin
                if (exp_vl.size() == 0) begin
                    check(cur_req, 1'b0, vl_out, 0);
                end else begin
                    logic [VLW-1:0] v;
                    v = exp_vl.pop_front();
                    check(cur_req, vl_out == v, vl_out, v);
                end
                // R9: single-cycle done
                check("R9", !prev_done, prev_done, 0);
            end
            prev_done = done;
        end
    end

    // Driver: model the expected writes and length, then run the request
    task automatic run_op(input string req, input int vl, input int ra, input int ba,
                          input bit rav, input bit bav, input int im, input bit ff,
                          input int sel, input bit pol, input bit inc, input bit poke);
        int processed = vl;
        int new_vl = vl;
        int cyc = 0;
        logic signed [XLEN-1:0] b;
        b = XLEN'(signed'(IMMW'(im)));
        for (int i = 0; i < vl; i++) begin
            logic signed [XLEN-1:0] a;
            logic [3:0] crv;
            logic fail;
            int src;
            int dst;
            src = (ra + (rav ? i : 0)) % NREG;
            dst = (ba + (bav ? i : 0)) % NCRF;
            a = rf[src];
            crv = {a < b, a > b, a == b, 1'b0};
            fail = ff && (crv[3-sel] == pol);
            if (!(fail && !inc)) exp_wr.push_back({CIDXW'(dst), crv});
            if (fail) begin
                processed = i + 1;
                new_vl = inc ? i + 1 : i;
                break;
            end
        end
        if (vl == 0) processed = 0;
        exp_vl.push_back(VLW'(new_vl));
        cur_req = req;
        vl_in = VLW'(vl); ra_base = RIDXW'(ra); ba_base = CIDXW'(ba);
        ra_vec = rav; ba_vec = bav; imm = IMMW'(im); ffirst_en = ff;
        test_sel = 2'(sel); test_pol = pol; incl = inc;
        start = 1'b1;
        forever begin
            @(negedge clk);
            cyc++;
            if (cyc == 1) start = 1'b0;
            if (poke && cyc == 2) begin
                // R10: a different request mid-run must be ignored
                vl_in = '0; ra_base = '0; ba_base = '0; imm = '0;
                ffirst_en = 1'b1; incl = 1'b0;
                start = 1'b1;
            end
            if (poke && cyc == 3) start = 1'b0;
            if (done || cyc > 200) break;
        end
        // R5: done appears one cycle after the last processed element
        check("R5", cyc == processed + 1, cyc, processed + 1);
        @(negedge clk);
        check(req, exp_wr.size() == 0, exp_wr.size(), 0);
        exp_wr.delete();
    endtask

    initial begin
        #(CLK_PER * 150000);
        check("watchdog", 1'b0, 0, 1);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int k = 0; k < NREG; k++) rf[k] = XLEN'(k * 7 - 100);
        repeat (3) @(negedge clk);
        check("R1", !busy && !done && !cr_we, {busy, done, cr_we}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", !busy && !done && !cr_we, {busy, done, cr_we}, 0);

        run_op("R5",  6, 10, 0, 1, 1, 0,  0, 0, 1, 1, 0);
        run_op("R3",  4, 20, 2, 0, 1, -5, 0, 0, 1, 1, 0);
        run_op("R4",  5, 3,  6, 1, 0, -80,0, 0, 1, 1, 0);
        run_op("R7",  8, 10, 0, 1, 1, 0,  1, 1, 1, 1, 0);
        run_op("R8",  8, 10, 0, 1, 1, 0,  1, 1, 1, 0, 0);
        run_op("R8",  3, 0,  1, 1, 1, 0,  1, 0, 1, 0, 0);
        run_op("R7",  3, 0,  1, 1, 1, 0,  1, 0, 1, 1, 0);
        run_op("R6",  6, 12, 4, 1, 1, -16,1, 2, 0, 1, 0);
        run_op("R6",  6, 10, 0, 1, 1, 0,  0, 0, 1, 0, 0);
        run_op("R2",  7, 8,  3, 1, 1, -44,1, 3, 1, 0, 0);
        run_op("R11", 0, 5,  5, 1, 1, 0,  0, 0, 1, 1, 0);
        run_op("R10", 6, 2,  1, 1, 1, 0,  0, 0, 1, 1, 1);
        run_op("R3",  VLMAX, 30, 7, 1, 1, 10, 0, 0, 1, 1, 0);
        run_op("R8",  VLMAX, 30, 7, 1, 1, 10, 1, 1, 0, 0, 0);

        repeat (3) @(negedge clk);
        check("R9", exp_vl.size() == 0, exp_vl.size(), 0);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule